// File: doc/BRIEF.md
# Serial Audio Pair Transmitter

This block turns one stereo pair of parallel audio samples per frame into a single-wire serial stream. It generates its own bit clock (half the system clock rate) and its own frame clock, so it acts as the timing master of the link. A seven-bit configuration word selects the frame length in bit clocks, which channel occupies the first half-frame slot, whether each sample leaves MSB-first or LSB-first, and how many bit clocks separate a frame-clock transition from the first data bit. These settings cover I2S (one-clock delay), left-justified (no delay), right-justified (delay chosen so the data ends at the slot end) and a two-slot TDM placement.

Samples enter through a valid/ready port backed by one holding register. At every frame start the held pair becomes the pair being sent. If nothing is held, the previous pair is sent again and an underrun pulse is raised. The configuration word is sampled only at frame starts. A setting whose data cannot fit in a half-frame slot, or a reserved frame code, raises an error flag and silences the data line for that whole frame.

Top module: `sap_tx`

## Requirements
- R1: While reset is held, bclk_o, lrclk_o, sdata_o, cfg_err_o and underrun_o are 0 and in_ready is 1.
- R2: bclk_o toggles on every system clock edge and starts at 0 after reset. lrclk_o, sdata_o and cfg_err_o change only on an edge where bclk_o falls.
- R3: cfg_i[6:4] selects the bit clocks per frame: 0 gives 64, 1 gives 32, 2 gives 48, 3 gives 128, 4 gives 256. lrclk_o is 0 for the first half of the frame and 1 for the second half.
- R4: cfg_i[1:0] sets the gap in bit clocks from each lrclk_o transition to the first bit of that slot: 0 gives 1, 1 gives 0, 2 gives 8, 3 gives 16.
- R5: cfg_i[2]=0 sends each sample MSB first. cfg_i[2]=1 sends it LSB first.
- R6: cfg_i[3]=0 puts the left sample in the first slot (lrclk_o low). cfg_i[3]=1 puts the right sample there.
- R7: Bit clocks in a slot that carry no sample bit drive sdata_o low.
- R8: If the delay plus SAMPLE_W exceeds half the frame length, or cfg_i[6:4] is 5, 6 or 7 (reserved codes, which use a 64-clock frame), cfg_err_o is 1 for that frame and sdata_o stays 0 throughout it.
- R9: cfg_i is sampled only at the start of a frame. A change during a frame alters nothing until the next frame.
- R10: in_ready is 1 exactly when the holding register is empty. A pair presented with in_valid while in_ready is 1 is taken on that edge and is sent starting at the next frame start.
- R11: If the holding register is empty at a frame start, the previous pair is sent again and underrun_o is 1 for exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 7 | Frame code [6:4], channel order [3], bit order [2], delay code [1:0] |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Holding register empty |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |
| cfg_err_o | output | 1 | Current frame's settings do not fit |
| underrun_o | output | 1 | One-clock pulse: pair repeated |

## Verification
At a frame start the block does three things on one edge: it latches a new configuration, it either takes the held pair or repeats the old one, and it may accept a new pair into the holding register. The bench provokes the clash in two ways. It changes cfg_i in the same window where it stops feeding, so that the new settings and the repeated pair start together. It also lets in_valid pulses land on the boundary edge itself. A cycle-accurate behavioural model predicts every output on every clock. That model decides from the holding state before the edge whether an underrun occurs, and it holds a pair accepted on the boundary edge until the next frame.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int LEN_W = 9;
    localparam int POS_W = LEN_W - 1;
    localparam int DLY_W = 5;
    localparam int CFG_W = 7;

    typedef struct packed {
        logic [LEN_W-1:0] flen;
        logic [DLY_W-1:0] dly;
        logic             rfirst;
        logic             lsbf;
        logic             err;
    } cfg_t;

    localparam cfg_t CFG_RST = '{flen: 9'd64, dly: 5'd1, rfirst: 1'b0, lsbf: 1'b0, err: 1'b0};
endpackage

// File: rtl/sap_cfg_decode.sv
module sap_cfg_decode
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic [CFG_W-1:0] cfg_byte,
    output cfg_t             cfg
);
    localparam logic [LEN_W-1:0] WID = LEN_W'(SAMPLE_W);

    logic [LEN_W-1:0] len;
    logic [DLY_W-1:0] dly;
    logic             rsvd;

    always_comb begin
        rsvd = 1'b0;
        case (cfg_byte[6:4])
            3'd0:    len = 9'd64;
            3'd1:    len = 9'd32;
            3'd2:    len = 9'd48;
            3'd3:    len = 9'd128;
            3'd4:    len = 9'd256;
            default: begin
                len  = 9'd64;
                rsvd = 1'b1;
            end
        endcase
        case (cfg_byte[1:0])
            2'd0:    dly = 5'd1;
            2'd1:    dly = 5'd0;
            2'd2:    dly = 5'd8;
            default: dly = 5'd16;
        endcase
        cfg.flen   = len;
        cfg.dly    = dly;
        cfg.rfirst = cfg_byte[3];
        cfg.lsbf   = cfg_byte[2];
        cfg.err    = rsvd || ((LEN_W'(dly) + WID) > (len >> 1));
    end
endmodule

// File: rtl/sap_bit_pick.sv
module sap_bit_pick
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic [POS_W-1:0]    pos,
    input  cfg_t                cfg,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    output logic                lr,
    output logic                bit_o
);
    localparam int IW = $clog2(SAMPLE_W);
    localparam logic [LEN_W-1:0] WID = LEN_W'(SAMPLE_W);

    logic [LEN_W-1:0]    half, p, off, dlyx, k;
    logic [SAMPLE_W-1:0] word;
    logic [IW-1:0]       idx;

    always_comb begin
        half  = cfg.flen >> 1;
        p     = {1'b0, pos};
        lr    = (p >= half);
        off   = lr ? (p - half) : p;
        dlyx  = LEN_W'(cfg.dly);
        k     = off - dlyx;
        word  = (lr ^ cfg.rfirst) ? right : left;
        idx   = cfg.lsbf ? IW'(k) : IW'(WID - 9'd1 - k);
        bit_o = (!cfg.err && (off >= dlyx) && (k < WID)) ? word[idx] : 1'b0;
    end
endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg_i,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sdata_o,
    output logic                cfg_err_o,
    output logic                underrun_o
);
    typedef struct packed {
        logic                phase;
        logic                init;
        logic [POS_W-1:0]    pos;
        cfg_t                cfg;
        logic [SAMPLE_W-1:0] act_l;
        logic [SAMPLE_W-1:0] act_r;
        logic [SAMPLE_W-1:0] buf_l;
        logic [SAMPLE_W-1:0] buf_r;
        logic                buf_v;
        logic                undr;
    } st_t;

    localparam st_t ST_RST = '{phase: 1'b0, init: 1'b1, pos: '0, cfg: CFG_RST,
                               act_l: '0, act_r: '0, buf_l: '0, buf_r: '0,
                               buf_v: 1'b0, undr: 1'b0};

    st_t  q, d;
    cfg_t dec;
    logic pk_lr, pk_bit, lr_q, sd_q;

    sap_cfg_decode #(.SAMPLE_W(SAMPLE_W)) u_dec (
        .cfg_byte (cfg_i),
        .cfg      (dec)
    );

    sap_bit_pick #(.SAMPLE_W(SAMPLE_W)) u_pick (
        .pos   (d.pos),
        .cfg   (d.cfg),
        .left  (d.act_l),
        .right (d.act_r),
        .lr    (pk_lr),
        .bit_o (pk_bit)
    );

    always_comb begin
        d       = q;
        d.phase = !q.phase;
        d.undr  = 1'b0;
        if (q.phase) begin
            if (q.init || ({1'b0, q.pos} == (q.cfg.flen - 9'd1))) begin
                d.init = 1'b0;
                d.pos  = '0;
                d.cfg  = dec;
                if (q.buf_v) begin
                    d.act_l = q.buf_l;
                    d.act_r = q.buf_r;
                    d.buf_v = 1'b0;
                end else begin
                    d.undr = 1'b1;
                end
            end else begin
                d.pos = q.pos + 1'b1;
            end
        end
        if (in_valid && !q.buf_v) begin
            d.buf_l = in_left;
            d.buf_r = in_right;
            d.buf_v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= ST_RST;
            lr_q <= 1'b0;
            sd_q <= 1'b0;
        end else begin
            q <= d;
            if (q.phase) begin
                lr_q <= pk_lr;
                sd_q <= pk_bit;
            end
        end
    end

    assign in_ready   = !q.buf_v;
    assign bclk_o     = q.phase;
    assign lrclk_o    = lr_q;
    assign sdata_o    = sd_q;
    assign cfg_err_o  = q.cfg.err;
    assign underrun_o = q.undr;
endmodule

// File: rtl/sap_tx_chk.sv
module sap_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic bclk_o,
    input logic lrclk_o,
    input logic sdata_o,
    input logic cfg_err_o,
    input logic underrun_o
);
    p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk_o) |-> $stable(lrclk_o));

    p_sd_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk_o) |-> $stable(sdata_o));

    p_err_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk_o) |-> $stable(cfg_err_o));

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !sdata_o);

    p_take_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_undr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);

    p_undr_at_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> $fell(bclk_o));
endmodule

bind sap_tx sap_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .sdata_o    (sdata_o),
    .cfg_err_o  (cfg_err_o),
    .underrun_o (underrun_o)
);

// File: tb/tb_sap_tx.sv
`timescale 1ns/1ps
module tb_sap_tx;
    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    cfg_i = 7'h00;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_left = '0, in_right = '0;
    logic          bclk_o, lrclk_o, sdata_o, cfg_err_o, underrun_o;

    sap_tx #(.SAMPLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdata_o(sdata_o),
        .cfg_err_o(cfg_err_o), .underrun_o(underrun_o)
    );

    always #2 clk = !clk;

    int    n_chk = 0, n_bad = 0, cyc = 0;
    bit    reported = 0, feed_en = 0;
    string cur_tag = "R4";
    logic [31:0] lfsr = 32'h1ACE_B00C;

    // behavioural model state
    bit m_phase, m_init, m_bufv, m_undr, m_lr, m_sd;
    int m_pos, m_flen, m_dly;
    bit m_rf, m_lb, m_err;
    logic [SW-1:0] m_al, m_ar, m_bl, m_br;

    task automatic chk(input bit ok, input string tag, input logic a, input logic e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, a, e, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic exp_bit(int pos);
        int half = m_flen / 2;
        int slot = (pos >= half) ? 1 : 0;
        int off  = pos - slot * half;
        int k    = off - m_dly;
        logic [SW-1:0] w = ((slot == 1) ^ m_rf) ? m_ar : m_al;
        if (m_err || k < 0 || k >= SW) return 1'b0;
        return m_lb ? w[k] : w[SW-1-k];
    endfunction

    function automatic logic [6:0] mk(int fc, int rf, int lb, int dl);
        return {3'(fc), 1'(rf), 1'(lb), 2'(dl)};
    endfunction

    always @(posedge clk) begin : model
        bit acc, bnd;
        int len, dl;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_init = 1; m_bufv = 0; m_undr = 0; m_lr = 0; m_sd = 0;
            m_pos = 0; m_flen = 64; m_dly = 1; m_rf = 0; m_lb = 0; m_err = 0;
            m_al = '0; m_ar = '0; m_bl = '0; m_br = '0;
        end else begin
            acc = in_valid && !m_bufv;
            m_undr = 0;
            if (m_phase) begin
                bnd = m_init || (m_pos == m_flen - 1);
                if (bnd) begin
                    m_init = 0; m_pos = 0;
                    case (cfg_i[6:4])
                        0: len = 64; 1: len = 32; 2: len = 48; 3: len = 128; 4: len = 256;
                        default: len = 64;
                    endcase
                    case (cfg_i[1:0])
                        0: dl = 1; 1: dl = 0; 2: dl = 8; default: dl = 16;
                    endcase
                    m_flen = len; m_dly = dl; m_rf = cfg_i[3]; m_lb = cfg_i[2];
                    m_err = (cfg_i[6:4] > 4) || (dl + SW > len / 2);
                    if (m_bufv) begin
                        m_al = m_bl; m_ar = m_br; m_bufv = 0;
                    end else m_undr = 1;
                end else m_pos++;
                m_lr = (m_pos >= m_flen / 2);
                m_sd = exp_bit(m_pos);
            end
            if (acc) begin m_bl = in_left; m_br = in_right; m_bufv = 1; end
            m_phase = !m_phase;
        end
        if (cyc > 150000 && !reported) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    always @(negedge clk) begin : compare
        if (!rst_n) begin
            // R1: reset state
            chk(bclk_o === 1'b0 && lrclk_o === 1'b0 && sdata_o === 1'b0, "R1",
                bclk_o | lrclk_o | sdata_o, 1'b0);
            chk(cfg_err_o === 1'b0 && underrun_o === 1'b0, "R1", cfg_err_o | underrun_o, 1'b0);
            chk(in_ready === 1'b1, "R1", in_ready, 1'b1);
        end else begin
            chk(bclk_o === m_phase, "R2", bclk_o, m_phase);
            chk(lrclk_o === m_lr, "R3", lrclk_o, m_lr);
            chk(sdata_o === m_sd, cur_tag, sdata_o, m_sd);
            chk(cfg_err_o === m_err, "R8", cfg_err_o, m_err);
            chk(underrun_o === m_undr, "R11", underrun_o, m_undr);
            chk(in_ready === !m_bufv, "R10", in_ready, !m_bufv);
        end
    end

    always @(negedge clk) begin : feeder
        if (rst_n && feed_en && in_ready) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            in_left  = lfsr[SW-1:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            in_right = lfsr[31:32-SW];
            in_valid = 1'b1;
        end else begin
            in_valid = 1'b0;
        end
    end

    task automatic run(input logic [6:0] c, input int clocks, input string tag);
        cur_tag = tag;
        cfg_i = c;
        repeat (clocks) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        feed_en = 1;
        run(mk(0, 0, 0, 0), 400, "R4");   // I2S one-clock delay
        run(mk(0, 0, 0, 1), 400, "R7");   // left-justified, tail padding
        run(mk(0, 0, 0, 2), 400, "R4");   // right-justified
        run(mk(0, 0, 1, 2), 400, "R5");   // LSB first
        run(mk(0, 1, 0, 0), 400, "R6");   // right channel first
        run(mk(2, 0, 0, 1), 300, "R3");   // 48 clocks, exact fit
        run(mk(2, 1, 1, 0), 300, "R8");   // 48 clocks, one bit too long
        run(mk(3, 0, 0, 3), 800, "R3");   // 128 clocks
        run(mk(4, 1, 0, 0), 1600, "R3");  // 256 clocks
        run(mk(1, 0, 0, 1), 200, "R8");   // 32 clocks cannot hold 24 bits
        run(mk(0, 0, 0, 3), 400, "R8");   // delay 16 overflows the slot
        run(mk(6, 0, 0, 1), 400, "R8");   // reserved frame code
        feed_en = 0;                      // R11 with R9: new settings and repeat together
        run(mk(0, 1, 1, 1), 500, "R11");
        feed_en = 1;
        run(mk(0, 0, 0, 0), 37, "R9");    // mid-frame change
        run(mk(3, 1, 0, 2), 700, "R9");
        report();
    end
endmodule